// File: doc/BRIEF.md
# Burst-Aligned Compression Mode Selector

This block sits behind a lossless entropy encoder in a memory controller's write path. For every 128-byte block the encoder reports how many bits the compressed image takes. The selector picks one of three ways to store the block: losslessly compressed, re-encoded with quantized low-order bits (lossy), or raw. It also works out the 2-bit burst-count metadata that tells the read path how many 32-byte bursts to fetch. The largest whole number of 256-bit bursts that fits inside the compressed size is the budget, and the bits beyond it are the spill. Lossy re-encoding is chosen only when that spill is non-zero, is no larger than a programmable threshold, and the region has been marked as tolerant of approximation.

Sizes arrive over a valid/ready handshake. Lossless and raw decisions appear one cycle after acceptance, so one decision can be made every cycle. A lossy choice raises a re-encode request and stalls new sizes. When the quantizing encoder returns the new size, the burst count is recomputed from it and the decision is issued. The threshold is a 10-bit register, in bits, loaded through a write strobe.

Top module: `csel_top`

## Requirements
- R1: After reset `size_ready` is 1, `dec_valid` and `reenc_req` are 0, and the threshold holds 128 bits.
- R2: A size below 256 bits gives mode RAW (encoding 2) with burst code 3, whatever the approximation flag is.
- R3: A size above 1024 bits gives mode RAW (encoding 2) with burst code 3.
- R4: A size from 256 to 1024 bits that is an exact multiple of 256 gives mode LOSSLESS (encoding 0) with no re-encode request. Its burst code is size/256 - 1.
- R5: A size from 256 to 1024 bits whose spill (size mod 256) is from 1 up to and including the threshold, with `size_approx_ok` set, raises `reenc_req` the cycle after acceptance. `size_ready` stays 0 and no decision is issued until a re-encoded size arrives.
- R6: A size from 256 to 1024 bits whose spill exceeds the threshold, or that arrives with `size_approx_ok` clear, gives mode LOSSLESS with burst code ceil(size/256) - 1.
- R7: `reenc_valid` while `reenc_req` is high produces, one cycle later, a decision with mode LOSSY (encoding 1). Its burst code is min(max(ceil(new/256),1),4) - 1. `reenc_req` drops and `size_ready` returns in the same cycle.
- R8: A write strobe loads the threshold at the clock edge. Sizes accepted after that edge use the new value.
- R9: Each accepted size yields exactly one single-cycle `dec_valid`. Lossless and raw decisions come one cycle after acceptance, and sizes may be accepted on consecutive cycles.
- R10: `reenc_valid` with no request pending is ignored: no decision is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| size_valid | input | 1 | A compressed size is offered |
| size_ready | output | 1 | Selector can accept a size |
| size_bits | input | 11 | Lossless compressed size in bits |
| size_approx_ok | input | 1 | Region of this block may be approximated |
| thr_wr_en | input | 1 | Load the spill threshold |
| thr_wr_val | input | 10 | New spill threshold in bits |
| reenc_req | output | 1 | Quantized re-encode requested, waiting for its size |
| reenc_valid | input | 1 | Re-encoded size is present |
| reenc_bits | input | 11 | Re-encoded size in bits |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_mode | output | 2 | 0 lossless, 1 lossy, 2 raw |
| dec_bursts | output | 2 | Number of 32-byte bursts minus one |

## Verification
The assertions assume that the re-encoding engine returns at most one size for each request. They also assume it drives `reenc_valid` only while `reenc_req` is high, except when a stray pulse is injected on purpose while idle, which the selector must ignore. They assume `rst_n` is already synchronous to `clk`. The bench offers sizes only at the falling edge. It returns re-encoded sizes only after it has seen the request. It injects the single stray re-encode pulse while the selector is idle, so every decision can be traced to one accepted size.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [1:0] {
    MODE_LOSSLESS = 2'd0,
    MODE_LOSSY    = 2'd1,
    MODE_RAW      = 2'd2
  } csel_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } csel_state_e;

endpackage

// File: rtl/csel_sizer.sv
// Burst count for a size in bits: ceil(size/unit), clamped to 1..MAX_UNITS,
// returned as count minus one.
module csel_sizer #(
  parameter int SIZE_W    = 11,
  parameter int UNIT_LOG  = 8,
  parameter int MAX_UNITS = 4,
  parameter int CNT_W     = 2
) (
  input  logic [SIZE_W-1:0] size_in,
  output logic [CNT_W-1:0]  code_out
);

  logic [SIZE_W-1:0] floor_u;
  logic [SIZE_W-1:0] ceil_u;
  logic              spill_nz;

  always_comb begin
    floor_u  = size_in >> UNIT_LOG;
    spill_nz = (size_in[UNIT_LOG-1:0] != '0);
    ceil_u   = floor_u + SIZE_W'(spill_nz);
    if (ceil_u == '0) begin
      code_out = '0;
    end else if (ceil_u >= SIZE_W'(MAX_UNITS)) begin
      code_out = CNT_W'(MAX_UNITS - 1);
    end else begin
      code_out = CNT_W'(ceil_u - SIZE_W'(1));
    end
  end

endmodule

// File: rtl/csel_classify.sv
// Chooses the storage mode for a freshly encoded block.
module csel_classify
  import csel_pkg::*;
#(
  parameter int SIZE_W     = 11,
  parameter int UNIT_LOG   = 8,
  parameter int BLOCK_BITS = 1024,
  parameter int THR_W      = 10
) (
  input  logic [SIZE_W-1:0] size_in,
  input  logic              approx_ok,
  input  logic [THR_W-1:0]  thr,
  output csel_mode_e        mode_out
);

  localparam int UNIT_BITS = 1 << UNIT_LOG;

  logic [THR_W-1:0] spill;
  logic             too_small;
  logic             too_large;

  always_comb begin
    spill     = THR_W'(size_in[UNIT_LOG-1:0]);
    too_small = size_in < SIZE_W'(UNIT_BITS);
    too_large = size_in > SIZE_W'(BLOCK_BITS);
    if (too_small || too_large) begin
      mode_out = MODE_RAW;
    end else if (approx_ok && (spill != '0) && (spill <= thr)) begin
      mode_out = MODE_LOSSY;
    end else begin
      mode_out = MODE_LOSSLESS;
    end
  end

endmodule

// File: rtl/csel_thresh_reg.sv
module csel_thresh_reg #(
  parameter int THR_W     = 10,
  parameter int THR_RESET = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [THR_W-1:0] wr_val,
  output logic [THR_W-1:0] thr_q
);

  logic [THR_W-1:0] thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= THR_W'(THR_RESET);
    else        thr_q <= thr_d;
  end

  // R8
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (thr_q == $past(wr_val)));

endmodule

// File: rtl/csel_ctrl.sv
// Handshake sequencing and decision registers.
module csel_ctrl
  import csel_pkg::*;
#(
  parameter int MAX_UNITS = 4,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             size_valid,
  output logic             size_ready,
  input  csel_mode_e       size_mode,
  input  logic [CNT_W-1:0] size_code,
  output logic             reenc_req,
  input  logic             reenc_valid,
  input  logic [CNT_W-1:0] reenc_code,
  output logic             dec_valid,
  output csel_mode_e       dec_mode,
  output logic [CNT_W-1:0] dec_code
);

  localparam logic [CNT_W-1:0] FULL_CODE = CNT_W'(MAX_UNITS - 1);

  csel_state_e      state_q, state_d;
  logic             dec_valid_d;
  csel_mode_e       dec_mode_d;
  logic [CNT_W-1:0] dec_code_d;
  logic             dec_load_en;

  assign size_ready = (state_q == ST_IDLE);
  assign reenc_req  = (state_q == ST_WAIT);

  always_comb begin
    state_d     = state_q;
    dec_valid_d = 1'b0;
    dec_mode_d  = size_mode;
    dec_code_d  = size_code;
    unique case (state_q)
      ST_IDLE: begin
        if (size_valid) begin
          if (size_mode == MODE_LOSSY) begin
            state_d = ST_WAIT;
          end else begin
            dec_valid_d = 1'b1;
            dec_mode_d  = size_mode;
            dec_code_d  = (size_mode == MODE_RAW) ? FULL_CODE : size_code;
          end
        end
      end
      ST_WAIT: begin
        if (reenc_valid) begin
          dec_valid_d = 1'b1;
          dec_mode_d  = MODE_LOSSY;
          dec_code_d  = reenc_code;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    dec_load_en = dec_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dec_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      dec_valid <= dec_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_mode <= MODE_LOSSLESS;
      dec_code <= '0;
    end else if (dec_load_en) begin
      dec_mode <= dec_mode_d;
      dec_code <= dec_code_d;
    end
  end

  // R5
  reenc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reenc_req) |-> $past(size_valid && size_ready));

  // R9
  dec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past((size_valid && size_ready) || (reenc_valid && reenc_req)));

  // R7
  lossy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_mode == MODE_LOSSY) |-> $past(reenc_valid && reenc_req));

  // R3
  raw_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_mode == MODE_RAW) |-> (dec_code == FULL_CODE));

  // R10
  stray_reenc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reenc_valid && !reenc_req) |=> (!dec_valid || dec_mode != MODE_LOSSY));

endmodule

// File: rtl/csel_top.sv
module csel_top
  import csel_pkg::*;
#(
  parameter int SIZE_W     = 11,
  parameter int UNIT_BITS  = 256,
  parameter int BLOCK_BITS = 1024,
  parameter int THR_W      = 10,
  parameter int THR_RESET  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_valid,
  output logic              size_ready,
  input  logic [SIZE_W-1:0] size_bits,
  input  logic              size_approx_ok,
  input  logic              thr_wr_en,
  input  logic [THR_W-1:0]  thr_wr_val,
  output logic              reenc_req,
  input  logic              reenc_valid,
  input  logic [SIZE_W-1:0] reenc_bits,
  output logic              dec_valid,
  output logic [1:0]        dec_mode,
  output logic [1:0]        dec_bursts
);

  localparam int UNIT_LOG  = $clog2(UNIT_BITS);
  localparam int MAX_UNITS = BLOCK_BITS / UNIT_BITS;
  localparam int CNT_W     = (MAX_UNITS > 1) ? $clog2(MAX_UNITS) : 1;

  logic [THR_W-1:0] thr_q;
  csel_mode_e       in_mode;
  csel_mode_e       out_mode;
  logic [CNT_W-1:0] in_code;
  logic [CNT_W-1:0] re_code;
  logic [CNT_W-1:0] out_code;

  csel_thresh_reg #(.THR_W(THR_W), .THR_RESET(THR_RESET)) thr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_en), .wr_val(thr_wr_val), .thr_q(thr_q)
  );

  csel_classify #(.SIZE_W(SIZE_W), .UNIT_LOG(UNIT_LOG), .BLOCK_BITS(BLOCK_BITS),
                  .THR_W(THR_W)) cls_i (
    .size_in(size_bits), .approx_ok(size_approx_ok), .thr(thr_q), .mode_out(in_mode)
  );

  csel_sizer #(.SIZE_W(SIZE_W), .UNIT_LOG(UNIT_LOG), .MAX_UNITS(MAX_UNITS),
               .CNT_W(CNT_W)) in_sz_i (
    .size_in(size_bits), .code_out(in_code)
  );

  csel_sizer #(.SIZE_W(SIZE_W), .UNIT_LOG(UNIT_LOG), .MAX_UNITS(MAX_UNITS),
               .CNT_W(CNT_W)) re_sz_i (
    .size_in(reenc_bits), .code_out(re_code)
  );

  csel_ctrl #(.MAX_UNITS(MAX_UNITS), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .size_valid(size_valid), .size_ready(size_ready),
    .size_mode(in_mode), .size_code(in_code),
    .reenc_req(reenc_req), .reenc_valid(reenc_valid), .reenc_code(re_code),
    .dec_valid(dec_valid), .dec_mode(out_mode), .dec_code(out_code)
  );

  assign dec_mode   = out_mode;
  assign dec_bursts = 2'(out_code);

endmodule

// File: tb/csel_top_tb_top.sv
`timescale 1ns/1ps
module csel_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        size_valid = 1'b0;
  logic        size_ready;
  logic [10:0] size_bits = '0;
  logic        size_approx_ok = 1'b0;
  logic        thr_wr_en = 1'b0;
  logic [9:0]  thr_wr_val = '0;
  logic        reenc_req;
  logic        reenc_valid = 1'b0;
  logic [10:0] reenc_bits = '0;
  logic        dec_valid;
  logic [1:0]  dec_mode;
  logic [1:0]  dec_bursts;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  csel_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .size_valid(size_valid), .size_ready(size_ready), .size_bits(size_bits),
    .size_approx_ok(size_approx_ok),
    .thr_wr_en(thr_wr_en), .thr_wr_val(thr_wr_val),
    .reenc_req(reenc_req), .reenc_valid(reenc_valid), .reenc_bits(reenc_bits),
    .dec_valid(dec_valid), .dec_mode(dec_mode), .dec_bursts(dec_bursts)
  );

  // {size[26:16], approx[15], mode[14:13], bursts-1[12:11], reencoded size[10:0]}
  localparam int NV = 14;
  localparam logic [26:0] VECS [NV] = '{
    {11'd100,  1'b1, 2'd2, 2'd3, 11'd0},    // R2
    {11'd255,  1'b1, 2'd2, 2'd3, 11'd0},    // R2
    {11'd256,  1'b1, 2'd0, 2'd0, 11'd0},    // R4
    {11'd257,  1'b1, 2'd1, 2'd0, 11'd250},  // R5 R7
    {11'd384,  1'b1, 2'd1, 2'd1, 11'd300},  // R5 spill equals threshold
    {11'd385,  1'b1, 2'd0, 2'd1, 11'd0},    // R6 spill one over
    {11'd512,  1'b1, 2'd0, 2'd1, 11'd0},    // R4
    {11'd600,  1'b0, 2'd0, 2'd2, 11'd0},    // R6 not approximable
    {11'd600,  1'b1, 2'd1, 2'd0, 11'd0},    // R7 clamp to one burst
    {11'd1024, 1'b1, 2'd0, 2'd3, 11'd0},    // R4
    {11'd1025, 1'b1, 2'd2, 2'd3, 11'd0},    // R3
    {11'd2047, 1'b0, 2'd2, 2'd3, 11'd0},    // R3
    {11'd900,  1'b1, 2'd0, 2'd3, 11'd0},    // R6
    {11'd800,  1'b1, 2'd1, 2'd3, 11'd1500}  // R7 clamp to four bursts
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_thr(input logic [9:0] v);
    @(negedge clk);
    thr_wr_en = 1'b1; thr_wr_val = v;
    @(negedge clk);
    thr_wr_en = 1'b0;
  endtask

  task automatic run_one(input logic [10:0] sz, input logic ap, input int md,
                         input int bc, input logic [10:0] rsz, input string req);
    @(negedge clk);
    size_bits = sz; size_approx_ok = ap; size_valid = 1'b1;
    @(negedge clk);
    size_valid = 1'b0;
    if (md == 1) begin
      check("R5", {req, " request"}, int'(reenc_req), 1);
      check("R5", {req, " ready held"}, int'(size_ready), 0);
      check("R5", {req, " no early decision"}, int'(dec_valid), 0);
      reenc_valid = 1'b1; reenc_bits = rsz;
      @(negedge clk);
      reenc_valid = 1'b0;
      check("R7", {req, " valid"}, int'(dec_valid), 1);
      check("R7", {req, " mode"}, int'(dec_mode), 1);
      check("R7", {req, " bursts"}, int'(dec_bursts), bc);
      check("R7", {req, " request dropped"}, int'(reenc_req), 0);
    end else begin
      check(req, "valid", int'(dec_valid), 1);
      check(req, "mode", int'(dec_mode), md);
      check(req, "bursts", int'(dec_bursts), bc);
      check(req, "no request", int'(reenc_req), 0);
    end
    @(negedge clk);
    check("R9", "single strobe", int'(dec_valid), 0);
  endtask

  task automatic run_all();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check("R1", "ready in reset", int'(size_ready), 1);
    check("R1", "no decision in reset", int'(dec_valid), 0);
    check("R1", "no request in reset", int'(reenc_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      string tag;
      v = VECS[i];
      if (v[14:13] == 2'd2)      tag = (v[26:16] < 11'd256) ? "R2" : "R3";
      else if (v[14:13] == 2'd1) tag = "R5";
      else                       tag = (v[26:16] % 256 == 0) ? "R4" : "R6";
      run_one(v[26:16], v[15], int'(v[14:13]), int'(v[12:11]), v[10:0], tag);
    end

    // R8: threshold 0 forbids lossy; threshold 1023 allows spill 255
    write_thr(10'd0);
    run_one(11'd257, 1'b1, 0, 1, 11'd0, "R8");
    write_thr(10'd1023);
    run_one(11'd511, 1'b1, 1, 1, 11'd511, "R8");
    write_thr(10'd128);
    run_one(11'd385, 1'b1, 0, 1, 11'd0, "R8");

    // R10: stray re-encode pulse while idle
    @(negedge clk);
    reenc_valid = 1'b1; reenc_bits = 11'd300;
    @(negedge clk);
    reenc_valid = 1'b0;
    check("R10", "no decision", int'(dec_valid), 0);
    check("R10", "still ready", int'(size_ready), 1);

    // R9: back-to-back acceptance
    @(negedge clk);
    size_bits = 11'd768; size_approx_ok = 1'b1; size_valid = 1'b1;
    @(negedge clk);
    check("R9", "first valid", int'(dec_valid), 1);
    check("R9", "first bursts", int'(dec_bursts), 2);
    size_bits = 11'd50;
    @(negedge clk);
    size_valid = 1'b0;
    check("R9", "second valid", int'(dec_valid), 1);
    check("R9", "second mode", int'(dec_mode), 2);

    // R5: sizes held off while waiting, accepted after the decision
    @(negedge clk);
    size_bits = 11'd257; size_approx_ok = 1'b1; size_valid = 1'b1;
    @(negedge clk);
    size_bits = 11'd100;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5", "stall no decision", int'(dec_valid), 0);
      check("R5", "stall not ready", int'(size_ready), 0);
    end
    reenc_valid = 1'b1; reenc_bits = 11'd700;
    @(negedge clk);
    reenc_valid = 1'b0;
    check("R7", "stalled lossy mode", int'(dec_mode), 1);
    check("R7", "stalled lossy bursts", int'(dec_bursts), 2);
    @(negedge clk);
    size_valid = 1'b0;
    check("R2", "held size valid", int'(dec_valid), 1);
    check("R2", "held size mode", int'(dec_mode), 2);
    @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule